// File: doc/BRIEF.md
# Auto-Reloading Audio Block DMA Sequencer

This block walks a circular buffer of fixed-size audio blocks held in memory and hands one block to the sample path on each periodic tick. Software sets the buffer's 32-bit base address in two 16-bit writes. It then writes a control word that carries a block count and an enable flag. When the enable flag goes from 0 to 1, the engine copies the base address and count into its working counters. Each tick while the engine is enabled issues a fetch request for the current block. The engine then moves its working address forward by one block and lowers its working count by one.

When the working count reaches zero, the engine reloads itself from the programmed registers and pulses the interrupt. The interrupt therefore marks the start of the next pass through the buffer, not the end of the last one. Software can write new base and count values while a pass is running. Those values are taken up at the next reload, so the software handler can queue the next buffer while the current one plays. A readback register reports how many blocks are left, counted from zero. While the engine is disabled, each tick emits a silent-block strobe in place of a memory fetch. A single interrupt also follows each enabling write after a fixed number of cycles.

Top module: `audio_blk_dma`

## Requirements
- R1: After synchronous reset, all four readback selectors return 0 and `req_valid`, `silent_valid` and `irq` are low.
- R2: A write with selector 0 sets address bits 31:16 and selector 1 sets bits 15:0. Selector 2 sets the control word: bit 15 is the enable and bits 14:0 are the block count. Selectors 0, 1 and 2 read back the stored values.
- R3: A control write that changes the enable from 0 to 1 loads the working address from the address register and the working count from the written count, at the same clock edge.
- R4: Address or control writes made while the engine is enabled leave the working address and count untouched. The new values are used at the next reload.
- R5: A tick while enabled with a nonzero working count makes `req_valid` high for one cycle on the following cycle. `req_addr` then equals the working address from before the tick. The working count drops by 1 and the working address rises by `BLOCK_BYTES` (32).
- R6: If the working count is zero after a tick while enabled, the working address and count reload from the programmed registers in the same edge, and `irq` is high on the following cycle.
- R7: Selector 3 reads the working count minus one, or 0 when the working count is 0. Writes with selector 3 change nothing.
- R8: A tick while disabled makes `silent_valid` high on the following cycle and makes no fetch request.
- R9: `irq` goes high exactly `START_DELAY` cycles (default 200) after the clock edge of an enabling control write. No other interrupt occurs in that window unless a reload causes one.
- R10: If the engine is enabled with a block count of 0, every tick makes no fetch request, reloads the engine and raises `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write selector (0 addr high, 1 addr low, 2 control, 3 blocks-left) |
| wr_data | input | 16 | Write data |
| rd_sel | input | 2 | Read selector, same encoding |
| rd_data | output | 16 | Combinational read data |
| tick | input | 1 | Single-cycle block-rate strobe |
| req_valid | output | 1 | One-cycle fetch request |
| req_addr | output | 32 | Address of the block being fetched |
| silent_valid | output | 1 | One-cycle strobe for a zero-sample block |
| irq | output | 1 | Buffer-start interrupt pulse |

## Verification
The hardest state to reach from the ports is a write that lands in the middle of a pass. New base and count values must stay hidden until the working count runs out, and they must then take effect on the very next fetch. The bench starts a four-block pass and consumes half of it. It then writes a new address and count while the engine is running. It checks that the remaining fetches still follow the old address, that the blocks-left readback keeps its old value, and that the reload interrupt loads the new count. The block-count sweep from 0 to 6 covers the case of zero blocks and the case where a single block reloads on every tick.

// File: rtl/abd_pkg.sv
package abd_pkg;

    localparam int ADDR_W = 32;
    localparam int HALF_W = ADDR_W / 2;
    localparam int CNT_W  = HALF_W - 1;

    typedef enum logic [1:0] {
        SEL_ADDR_HI = 2'd0,
        SEL_ADDR_LO = 2'd1,
        SEL_CTRL    = 2'd2,
        SEL_LEFT    = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             en;
        logic [CNT_W-1:0] nblk;
    } ctrl_t;

    function automatic logic [CNT_W-1:0] left_of(input logic [CNT_W-1:0] c);
        return (c == '0) ? '0 : c - 1'b1;
    endfunction

endpackage

// File: rtl/abd_regs.sv
module abd_regs
    import abd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [1:0]            wr_sel,
    input  logic [HALF_W-1:0]     wr_data,
    input  logic [1:0]            rd_sel,
    input  logic [CNT_W-1:0]      work_cnt,
    output logic [HALF_W-1:0]     rd_data,
    output logic [ADDR_W-1:0]     src_addr,
    output ctrl_t                 ctrl,
    output logic                  en_rise,
    output logic [CNT_W-1:0]      new_cnt
);

    ctrl_t wr_ctrl;

    always_comb begin
        wr_ctrl = ctrl_t'(wr_data);
        new_cnt = wr_ctrl.nblk;
        en_rise = wr_en && (reg_sel_e'(wr_sel) == SEL_CTRL) && wr_ctrl.en && !ctrl.en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_addr <= '0;
            ctrl     <= '0;
        end else if (wr_en) begin
            case (reg_sel_e'(wr_sel))
                SEL_ADDR_HI: src_addr[ADDR_W-1:HALF_W] <= wr_data;
                SEL_ADDR_LO: src_addr[HALF_W-1:0]      <= wr_data;
                SEL_CTRL:    ctrl                      <= wr_ctrl;
                default:     ;
            endcase
        end
    end

    always_comb begin
        case (reg_sel_e'(rd_sel))
            SEL_ADDR_HI: rd_data = src_addr[ADDR_W-1:HALF_W];
            SEL_ADDR_LO: rd_data = src_addr[HALF_W-1:0];
            SEL_CTRL:    rd_data = ctrl;
            default:     rd_data = {1'b0, left_of(work_cnt)};
        endcase
    end

    assert_ignore_left_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd3) |=> ($stable(src_addr) && $stable(ctrl)));

endmodule

// File: rtl/abd_engine.sv
module abd_engine
    import abd_pkg::*;
#(
    parameter int BLOCK_BYTES = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  en,
    input  logic                  en_rise,
    input  logic [CNT_W-1:0]      new_cnt,
    input  logic [CNT_W-1:0]      prog_cnt,
    input  logic [ADDR_W-1:0]     src_addr,
    input  logic                  tick,
    output logic [CNT_W-1:0]      work_cnt,
    output logic [ADDR_W-1:0]     work_addr,
    output logic                  req_valid,
    output logic [ADDR_W-1:0]     req_addr,
    output logic                  silent_valid,
    output logic                  reload_now
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BLOCK_BYTES);

    logic [CNT_W-1:0] cnt_after;
    logic             fetch;
    logic             live_tick;

    always_comb begin
        live_tick  = tick && en;
        fetch      = live_tick && (work_cnt != '0);
        cnt_after  = (work_cnt != '0) ? work_cnt - 1'b1 : '0;
        reload_now = live_tick && (cnt_after == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            work_cnt     <= '0;
            work_addr    <= '0;
            req_valid    <= 1'b0;
            req_addr     <= '0;
            silent_valid <= 1'b0;
        end else begin
            req_valid    <= fetch;
            silent_valid <= tick && !en;
            if (fetch) req_addr <= work_addr;
            if (en_rise) begin
                work_addr <= src_addr;
                work_cnt  <= new_cnt;
            end else if (live_tick) begin
                if (reload_now) begin
                    work_addr <= src_addr;
                    work_cnt  <= prog_cnt;
                end else begin
                    work_addr <= work_addr + STEP;
                    work_cnt  <= cnt_after;
                end
            end
        end
    end

    assert_latch_R3: assert property (@(posedge clk) disable iff (rst)
        en_rise |=> (work_cnt == $past(new_cnt) && work_addr == $past(src_addr)));

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (en && !tick) |=> ($stable(work_cnt) && $stable(work_addr)));

    assert_fetch_R5: assert property (@(posedge clk) disable iff (rst)
        (tick && en && work_cnt != '0) |=> (req_valid && req_addr == $past(work_addr)));

    assert_silent_R8: assert property (@(posedge clk) disable iff (rst)
        (tick && !en) |=> (silent_valid && !req_valid));

    assert_nofetch_R10: assert property (@(posedge clk) disable iff (rst)
        (tick && en && work_cnt == '0) |=> !req_valid);

endmodule

// File: rtl/abd_irq.sv
module abd_irq #(
    parameter int START_DELAY = 200,
    localparam int DLY_W = $clog2(START_DELAY + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic reload_now,
    output logic irq
);

    logic [DLY_W-1:0] dly;

    always_ff @(posedge clk) begin
        if (rst) begin
            dly <= '0;
            irq <= 1'b0;
        end else begin
            irq <= reload_now || (dly == DLY_W'(1));
            if (start)
                dly <= DLY_W'(START_DELAY);
            else if (dly != '0)
                dly <= dly - 1'b1;
        end
    end

    assert_start_irq_R9: assert property (@(posedge clk) disable iff (rst)
        (dly == DLY_W'(1) && !start) |=> irq);

    assert_reload_irq_R6: assert property (@(posedge clk) disable iff (rst)
        reload_now |=> irq);

    assert_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (!reload_now && dly != DLY_W'(1)) |=> !irq);

endmodule

// File: rtl/audio_blk_dma.sv
module audio_blk_dma
    import abd_pkg::*;
#(
    parameter int BLOCK_BYTES = 32,
    parameter int START_DELAY = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [HALF_W-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    output logic [HALF_W-1:0] rd_data,
    input  logic              tick,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic              silent_valid,
    output logic              irq
);

    logic [ADDR_W-1:0] src_addr;
    ctrl_t             ctrl;
    logic              en_rise;
    logic [CNT_W-1:0]  new_cnt;
    logic [CNT_W-1:0]  work_cnt;
    logic [ADDR_W-1:0] work_addr;
    logic              reload_now;

    abd_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .rd_sel   (rd_sel),
        .work_cnt (work_cnt),
        .rd_data  (rd_data),
        .src_addr (src_addr),
        .ctrl     (ctrl),
        .en_rise  (en_rise),
        .new_cnt  (new_cnt)
    );

    abd_engine #(.BLOCK_BYTES(BLOCK_BYTES)) u_engine (
        .clk          (clk),
        .rst          (rst),
        .en           (ctrl.en),
        .en_rise      (en_rise),
        .new_cnt      (new_cnt),
        .prog_cnt     (ctrl.nblk),
        .src_addr     (src_addr),
        .tick         (tick),
        .work_cnt     (work_cnt),
        .work_addr    (work_addr),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .silent_valid (silent_valid),
        .reload_now   (reload_now)
    );

    abd_irq #(.START_DELAY(START_DELAY)) u_irq (
        .clk        (clk),
        .rst        (rst),
        .start      (en_rise),
        .reload_now (reload_now),
        .irq        (irq)
    );

    assert_one_kind_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({req_valid, silent_valid}));

    assert_step_R5: assert property (@(posedge clk) disable iff (rst)
        (tick && ctrl.en && work_cnt > 1) |=> work_addr == $past(work_addr) + ADDR_W'(BLOCK_BYTES));

endmodule

// File: tb/audio_blk_dma_tb.sv
module audio_blk_dma_tb;

    localparam int D   = 200;
    localparam int BLK = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_sel = '0;
    logic [15:0] rd_data;
    logic        tick = 1'b0;
    logic        req_valid;
    logic [31:0] req_addr;
    logic        silent_valid;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    audio_blk_dma #(.BLOCK_BYTES(BLK), .START_DELAY(D)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .tick(tick), .req_valid(req_valid),
        .req_addr(req_addr), .silent_valid(silent_valid), .irq(irq)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rdchk(input string req, input logic [1:0] sel, input logic [15:0] exp);
        rd_sel = sel;
        #1;
        check(req, $sformatf("readback sel %0d", sel), {16'h0, rd_data}, {16'h0, exp});
        @(negedge clk);
    endtask

    task automatic do_tick();
        tick = 1'b1;
        @(posedge clk); @(negedge clk);
        tick = 1'b0;
    endtask

    // called at the negedge right after the enabling write edge
    task automatic wait_start_irq();
        int early = 0;
        for (int k = 1; k <= D + 1; k++) begin
            @(negedge clk);
            if (k == D) check("R9", "start irq at delay", {31'h0, irq}, 32'h1);
            else if (irq) early++;
        end
        check("R9", "no other irq in window", early, 0);
    endtask

    task automatic run_lap(input logic [31:0] base, input int n);
        for (int i = 0; i < n; i++) begin
            do_tick();
            check("R5", "fetch valid", {31'h0, req_valid}, 32'h1);
            check("R5", "fetch addr", req_addr, base + i * BLK);
            check("R6", "irq at end of pass", {31'h0, irq}, {31'h0, (i == n - 1)});
            rdchk("R7", 2'd3, (i == n - 1) ? 16'(n - 1) : 16'(n - 2 - i));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual expired expected done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] base;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", "irq", {31'h0, irq}, 0);
        check("R1", "req_valid", {31'h0, req_valid}, 0);
        check("R1", "silent_valid", {31'h0, silent_valid}, 0);
        for (int s = 0; s < 4; s++) rdchk("R1", 2'(s), 16'h0);

        // R8 disabled tick
        do_tick();
        check("R8", "silent strobe", {31'h0, silent_valid}, 1);
        check("R8", "no fetch", {31'h0, req_valid}, 0);

        // sweep of block counts
        for (int n = 0; n <= 6; n++) begin
            base = 32'h1230_0000 + n * 32'h440;
            wr(2'd0, base[31:16]);
            wr(2'd1, base[15:0]);
            wr(2'd2, 16'h8000 | 16'(n));
            wait_start_irq();
            rdchk("R2", 2'd0, base[31:16]);
            rdchk("R2", 2'd1, base[15:0]);
            rdchk("R2", 2'd2, 16'h8000 | 16'(n));
            rdchk("R3", 2'd3, (n == 0) ? 16'h0 : 16'(n - 1));
            if (n == 0) begin
                for (int t = 0; t < 3; t++) begin
                    do_tick();
                    check("R10", "no fetch", {31'h0, req_valid}, 0);
                    check("R10", "irq each tick", {31'h0, irq}, 1);
                    rdchk("R10", 2'd3, 16'h0);
                end
            end else begin
                run_lap(base, n);
                run_lap(base, n);
            end
            // R7 write to blocks-left has no effect
            wr(2'd3, 16'hFFFF);
            rdchk("R7", 2'd3, (n == 0) ? 16'h0 : 16'(n - 1));
            rdchk("R7", 2'd2, 16'h8000 | 16'(n));
            rdchk("R7", 2'd0, base[31:16]);
            wr(2'd2, 16'h0000);
            do_tick();
            check("R8", "silent after disable", {31'h0, silent_valid}, 1);
            check("R8", "no fetch after disable", {31'h0, req_valid}, 0);
        end

        // R4 pending settings while running
        base = 32'h0004_0000;
        wr(2'd0, base[31:16]);
        wr(2'd1, base[15:0]);
        wr(2'd2, 16'h8004);
        wait_start_irq();
        do_tick();
        check("R4", "first addr", req_addr, base);
        do_tick();
        check("R4", "second addr", req_addr, base + BLK);
        wr(2'd0, 16'h0009);
        wr(2'd1, 16'h8000);
        wr(2'd2, 16'h8003);
        check("R4", "no irq on running write", {31'h0, irq}, 0);
        rdchk("R4", 2'd3, 16'd1);
        do_tick();
        check("R4", "old addr kept", req_addr, base + 2 * BLK);
        check("R4", "no irq yet", {31'h0, irq}, 0);
        do_tick();
        check("R4", "last old addr", req_addr, base + 3 * BLK);
        check("R4", "reload irq", {31'h0, irq}, 1);
        rdchk("R4", 2'd3, 16'd2);
        do_tick();
        check("R4", "new addr used", req_addr, 32'h0009_8000);
        check("R4", "no irq mid pass", {31'h0, irq}, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule